// File: doc/BRIEF.md
# Two-Way Write-Back Data Cache with Three-State Coherency

This block is the controller and storage of a physically addressed data cache with two ways per set. Its lines are written back, and each line holds one of three coherency codes: Invalid, Exclusive or Modified. There is no Shared state. The processor presents one read or write at a time on a valid/ready request channel, and the cache answers with a one-cycle response pulse. A read response carries the addressed word; a write response acknowledges that the bytes were merged.

On a miss the cache picks a victim in the indexed set. A dirty victim is written out as a burst castout, and then the missing line is fetched as a burst fill. Other bus masters send snoops on a separate valid/ready channel. A snooped read that finds a Modified line pushes it out and drops it, so a peer with four coherency states never sees a stale copy. A snooped kill discards the line in any state.

On the bus, requests, write beats and read beats each have their own channel:

- **Requests:** a request is held, with its address and direction stable, until `bus_req_ready` is seen.
- **Write beats:** each write beat is held, with its data stable, until `bus_wready`.
- **Read beats:** read beats are always accepted.
- **Processor request:** may wait for any number of cycles.
- **Response:** carries no back-pressure.

Top module: `mei_cache_ctrl`

## Requirements
- R1: After reset every line is Invalid and all outputs are idle (`req_ready` high, `resp_valid`, `bus_req_valid` and `bus_wvalid` low), so the first access to any address causes a fill.
- R2: An address splits into tag (top bits), set index (the next log2(SETS) bits) and byte offset (the low log2(LINE_BYTES) bits). Bus requests carry line-aligned addresses. Each burst moves exactly LINE_BYTES/4 words, lowest address first.
- R3: A read miss fills the line into the Exclusive state and returns the requested word. A later read of that line returns the word with no bus request.
- R4: A write hit merges the write data under `req_be`, where bit i selects bits 8i+7..8i. The line becomes Modified with no bus request.
- R5: A write miss fills the line and then merges the write into it, leaving the line Modified.
- R6: The victim is chosen in this order: way 0 if it is Invalid, then way 1 if it is Invalid, otherwise the least recently used way. Every hit and every fill makes the other way of the set the least recently used.
- R7: A Modified victim is written out as a complete burst castout before the fill request is issued. A clean victim is overwritten with no castout.
- R8: A snooped read works as follows:
  - If it hits a Modified line, it produces a castout and the line then becomes Invalid.
  - If it hits an Exclusive line, the line becomes Invalid with no bus traffic.
  - If it misses, nothing changes.
- R9: A snooped kill (`snoop_kill`=1) invalidates a hit line in any state with no castout, and Modified data is discarded.
- R10: When the cache is idle, a pending snoop is accepted ahead of a processor request (`req_ready` is low while `snoop_valid` is high). Neither channel is accepted while a lookup, castout or fill is in progress.
- R11: `bus_req_valid` holds its address and direction until `bus_req_ready`. `bus_wvalid` holds its data until `bus_wready`. `resp_valid` never lasts more than one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Processor request accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Physical byte address |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte enables for a write |
| resp_valid | output | 1 | One-cycle completion pulse |
| resp_rdata | output | 32 | Read word, valid with `resp_valid` |
| snoop_valid | input | 1 | Snoop from another master |
| snoop_ready | output | 1 | Snoop accepted this cycle |
| snoop_kill | input | 1 | 1 = write/kill snoop, 0 = read snoop |
| snoop_addr | input | ADDR_W | Snooped physical address |
| bus_req_valid | output | 1 | Burst request present |
| bus_req_ready | input | 1 | Burst request taken by the bus |
| bus_req_write | output | 1 | 1 = castout, 0 = fill |
| bus_req_addr | output | ADDR_W | Line-aligned burst address |
| bus_wvalid | output | 1 | Castout beat present |
| bus_wready | input | 1 | Castout beat taken |
| bus_wdata | output | 32 | Castout beat data |
| bus_rvalid | input | 1 | Fill beat present |
| bus_rdata | input | 32 | Fill beat data |

## Verification
The assertions take three things for granted about the inputs:

- The bus returns exactly LINE_BYTES/4 read beats after each accepted fill request.
- The bus raises no read beat at any other time.
- Write-beat acceptance only matters while a castout is in progress.

The bench responder meets this by construction: it serves one burst at a time and stretches the request handshake for castouts to exercise the hold rules. Processor and snoop stimulus is driven at negative edges. The bench waits for the ready signal before it drops valid, so no request is withdrawn before it is accepted.

// File: rtl/mei_cache_pkg.sv
package mei_cache_pkg;
  typedef enum logic [1:0] {LN_INV = 2'd0, LN_EXC = 2'd1, LN_MOD = 2'd2} line_st_e;
  typedef enum logic [2:0] {
    C_IDLE, C_LOOK, C_SNP, C_CO_REQ, C_CO_DAT, C_FL_REQ, C_FL_DAT
  } ctl_st_e;
endpackage

// File: rtl/mei_tag_store.sv
module mei_tag_store
  import mei_cache_pkg::*;
#(
  parameter int SETS  = 128,
  parameter int TAG_W = 20,
  localparam int IW   = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IW-1:0]    idx,
  output logic [TAG_W-1:0] tag_o [2],
  output line_st_e         st_o  [2],
  output logic             lru_o,
  input  logic             upd_en,
  input  logic             upd_way,
  input  logic             upd_tag_en,
  input  logic [TAG_W-1:0] upd_tag,
  input  line_st_e         upd_st,
  input  logic             lru_en,
  input  logic             lru_val
);
  logic [SETS-1:0] lru_q;

  for (genvar w = 0; w < 2; w++) begin : g_way
    logic [TAG_W-1:0] tags [SETS];
    line_st_e         sts  [SETS];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int s = 0; s < SETS; s++) sts[s] <= LN_INV;
      end else if (upd_en && upd_way == 1'(w)) begin
        sts[idx] <= upd_st;
      end
    end

    always_ff @(posedge clk) begin
      if (upd_en && upd_tag_en && upd_way == 1'(w)) tags[idx] <= upd_tag;
    end

    assign tag_o[w] = tags[idx];
    assign st_o[w]  = sts[idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lru_q      <= '0;
    else if (lru_en) lru_q[idx] <= lru_val;
  end

  assign lru_o = lru_q[idx];
endmodule

// File: rtl/mei_data_store.sv
module mei_data_store #(
  parameter int SETS  = 128,
  parameter int BEATS = 8,
  localparam int IW   = $clog2(SETS),
  localparam int WW   = $clog2(BEATS)
) (
  input  logic          clk,
  input  logic [IW-1:0] idx,
  input  logic          rd_way,
  input  logic [WW-1:0] rd_word,
  output logic [31:0]   rd_data,
  input  logic          wr_en,
  input  logic          wr_way,
  input  logic [WW-1:0] wr_word,
  input  logic [31:0]   wr_data,
  input  logic [3:0]    wr_be
);
  logic [31:0] rd_w [2];

  for (genvar w = 0; w < 2; w++) begin : g_way
    logic [31:0] words [SETS*BEATS];

    always_ff @(posedge clk) begin
      if (wr_en && wr_way == 1'(w)) begin
        for (int b = 0; b < 4; b++) begin
          if (wr_be[b]) words[{idx, wr_word}][8*b +: 8] <= wr_data[8*b +: 8];
        end
      end
    end

    assign rd_w[w] = words[{idx, rd_word}];
  end

  assign rd_data = rd_w[rd_way];
endmodule

// File: rtl/mei_cache_ctrl.sv
module mei_cache_ctrl
  import mei_cache_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int SETS       = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  input  logic [3:0]        req_be,
  output logic              resp_valid,
  output logic [31:0]       resp_rdata,
  input  logic              snoop_valid,
  output logic              snoop_ready,
  input  logic              snoop_kill,
  input  logic [ADDR_W-1:0] snoop_addr,
  output logic              bus_req_valid,
  input  logic              bus_req_ready,
  output logic              bus_req_write,
  output logic [ADDR_W-1:0] bus_req_addr,
  output logic              bus_wvalid,
  input  logic              bus_wready,
  output logic [31:0]       bus_wdata,
  input  logic              bus_rvalid,
  input  logic [31:0]       bus_rdata
);
  localparam int BEATS = LINE_BYTES / 4;
  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam int IDX_W = $clog2(SETS);
  localparam int WRD_W = $clog2(BEATS);
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W;

  ctl_st_e           st_q, st_d;
  logic [ADDR_W-1:0] addr_q;
  logic              wr_q, snp_q, kill_q, way_q;
  logic [31:0]       wdata_q;
  logic [3:0]        be_q;
  logic [WRD_W-1:0]  beat_q;

  logic [IDX_W-1:0]  idx;
  logic [TAG_W-1:0]  tag;
  logic [WRD_W-1:0]  word;
  logic [TAG_W-1:0]  tg [2];
  line_st_e          ls [2];
  logic              lru, hit0, hit1, hit, hway, vway, last_beat;

  logic              tu_en, tu_way, tu_tag_en, lru_en, lru_val;
  line_st_e          tu_st;
  logic              dwe, dway, rd_way;
  logic [WRD_W-1:0]  dword, rd_word;
  logic [31:0]       dwdata, rd_data;
  logic [3:0]        dbe;
  logic              unused_lo;

  assign idx       = addr_q[OFF_W +: IDX_W];
  assign tag       = addr_q[ADDR_W-1 -: TAG_W];
  assign word      = addr_q[2 +: WRD_W];
  assign unused_lo = ^addr_q[1:0];

  assign hit0 = (ls[0] != LN_INV) && (tg[0] == tag);
  assign hit1 = (ls[1] != LN_INV) && (tg[1] == tag);
  assign hit  = hit0 | hit1;
  assign hway = hit1;
  assign vway = (ls[0] == LN_INV) ? 1'b0 : (ls[1] == LN_INV) ? 1'b1 : lru;
  assign last_beat = (beat_q == WRD_W'(BEATS - 1));

  assign rd_way     = (st_q == C_CO_DAT) ? way_q  : hway;
  assign rd_word    = (st_q == C_CO_DAT) ? beat_q : word;
  assign resp_rdata = rd_data;
  assign bus_wdata  = rd_data;

  mei_tag_store #(.SETS(SETS), .TAG_W(TAG_W)) u_tags (
    .clk, .rst_n, .idx, .tag_o(tg), .st_o(ls), .lru_o(lru),
    .upd_en(tu_en), .upd_way(tu_way), .upd_tag_en(tu_tag_en), .upd_tag(tag),
    .upd_st(tu_st), .lru_en, .lru_val
  );

  mei_data_store #(.SETS(SETS), .BEATS(BEATS)) u_data (
    .clk, .idx, .rd_way, .rd_word, .rd_data,
    .wr_en(dwe), .wr_way(dway), .wr_word(dword), .wr_data(dwdata), .wr_be(dbe)
  );

  always_comb begin
    st_d          = st_q;
    req_ready     = 1'b0;
    snoop_ready   = 1'b0;
    resp_valid    = 1'b0;
    bus_req_valid = 1'b0;
    bus_req_write = 1'b0;
    bus_req_addr  = {tag, idx, {OFF_W{1'b0}}};
    bus_wvalid    = 1'b0;
    tu_en = 1'b0; tu_way = way_q; tu_tag_en = 1'b0; tu_st = LN_INV;
    lru_en = 1'b0; lru_val = 1'b0;
    dwe = 1'b0; dway = way_q; dword = beat_q; dwdata = bus_rdata; dbe = 4'hF;
    unique case (st_q)
      C_IDLE: begin
        snoop_ready = 1'b1;
        req_ready   = !snoop_valid;
        if (snoop_valid)    st_d = C_SNP;
        else if (req_valid) st_d = C_LOOK;
      end
      C_LOOK: begin
        if (hit) begin
          resp_valid = 1'b1;
          lru_en     = 1'b1;
          lru_val    = ~hway;
          if (wr_q) begin
            dwe = 1'b1; dway = hway; dword = word; dwdata = wdata_q; dbe = be_q;
            tu_en = 1'b1; tu_way = hway; tu_st = LN_MOD;
          end
          st_d = C_IDLE;
        end else begin
          st_d = (ls[vway] == LN_MOD) ? C_CO_REQ : C_FL_REQ;
        end
      end
      C_SNP: begin
        st_d = C_IDLE;
        if (hit) begin
          if (!kill_q && ls[hway] == LN_MOD) begin
            st_d = C_CO_REQ;
          end else begin
            tu_en = 1'b1; tu_way = hway; tu_st = LN_INV;
          end
        end
      end
      C_CO_REQ: begin
        bus_req_valid = 1'b1;
        bus_req_write = 1'b1;
        bus_req_addr  = {tg[way_q], idx, {OFF_W{1'b0}}};
        if (bus_req_ready) st_d = C_CO_DAT;
      end
      C_CO_DAT: begin
        bus_wvalid = 1'b1;
        if (bus_wready && last_beat) begin
          if (snp_q) begin
            tu_en = 1'b1; tu_st = LN_INV;
            st_d  = C_IDLE;
          end else begin
            st_d = C_FL_REQ;
          end
        end
      end
      C_FL_REQ: begin
        bus_req_valid = 1'b1;
        if (bus_req_ready) st_d = C_FL_DAT;
      end
      C_FL_DAT: begin
        if (bus_rvalid) begin
          dwe = 1'b1;
          if (last_beat) begin
            tu_en = 1'b1; tu_tag_en = 1'b1; tu_st = LN_EXC;
            lru_en = 1'b1; lru_val = ~way_q;
            st_d = C_LOOK;
          end
        end
      end
      default: st_d = C_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= C_IDLE; addr_q <= '0; wr_q <= 1'b0; snp_q <= 1'b0; kill_q <= 1'b0;
      way_q <= 1'b0; wdata_q <= '0; be_q <= '0; beat_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == C_IDLE) begin
        if (snoop_valid) begin
          addr_q <= snoop_addr; snp_q <= 1'b1; kill_q <= snoop_kill;
        end else if (req_valid) begin
          addr_q <= req_addr; snp_q <= 1'b0; wr_q <= req_write;
          wdata_q <= req_wdata; be_q <= req_be;
        end
      end
      if (st_q == C_LOOK && !hit) way_q <= vway;
      if (st_q == C_SNP && hit)   way_q <= hway;
      if (st_d != st_q) beat_q <= '0;
      else if ((st_q == C_CO_DAT && bus_wready) || (st_q == C_FL_DAT && bus_rvalid))
        beat_q <= beat_q + 1'b1;
    end
  end
endmodule

// File: rtl/mei_cache_chk.sv
module mei_cache_chk #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              snoop_valid,
  input logic              snoop_ready,
  input logic              resp_valid,
  input logic              bus_req_valid,
  input logic              bus_req_ready,
  input logic              bus_req_write,
  input logic [ADDR_W-1:0] bus_req_addr,
  input logic              bus_wvalid,
  input logic              bus_wready,
  input logic [31:0]       bus_wdata,
  input logic              bus_rvalid
);
  localparam int BEATS = LINE_BYTES / 4;
  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam int CW    = $clog2(BEATS) + 2;

  logic [CW-1:0] beat_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) beat_cnt <= '0;
    else if (bus_req_valid && bus_req_ready) beat_cnt <= '0;
    else if ((bus_wvalid && bus_wready) || bus_rvalid) beat_cnt <= beat_cnt + CW'(1);
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_valid && !bus_req_ready |=> bus_req_valid && $stable(bus_req_addr) && $stable(bus_req_write)); // R11
  AST_WDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wvalid && !bus_wready |=> bus_wvalid && $stable(bus_wdata)); // R11
  AST_RESP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid); // R11
  AST_LINE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_valid |-> bus_req_addr[OFF_W-1:0] == '0); // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    beat_cnt <= CW'(BEATS)); // R2
  AST_SNOOP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    snoop_valid && snoop_ready |-> !req_ready); // R10
  AST_BUSY_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wvalid || bus_req_valid) |-> !req_ready && !snoop_ready); // R10
  AST_CASTOUT_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_valid |-> !bus_wvalid); // R7
endmodule

bind mei_cache_ctrl mei_cache_chk #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .snoop_valid(snoop_valid),
  .snoop_ready(snoop_ready), .resp_valid(resp_valid), .bus_req_valid(bus_req_valid),
  .bus_req_ready(bus_req_ready), .bus_req_write(bus_req_write), .bus_req_addr(bus_req_addr),
  .bus_wvalid(bus_wvalid), .bus_wready(bus_wready), .bus_wdata(bus_wdata),
  .bus_rvalid(bus_rvalid)
);

// File: tb/mei_cache_ctrl_test.sv
`timescale 1ns/1ps
module mei_cache_ctrl_test;
  localparam int AW = 12, LB = 16, NS = 4, BEATS = LB / 4, MW = 1024;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, snoop_valid = 0, snoop_kill = 0;
  logic [AW-1:0] req_addr = '0, snoop_addr = '0;
  logic [31:0] req_wdata = '0, bus_rdata = '0;
  logic [3:0] req_be = '0;
  logic bus_req_ready = 0, bus_wready = 0, bus_rvalid = 0;
  logic req_ready, resp_valid, snoop_ready, bus_req_valid, bus_req_write, bus_wvalid;
  logic [31:0] resp_rdata, bus_wdata;
  logic [AW-1:0] bus_req_addr;

  logic [31:0] mem [MW];
  logic [31:0] golden [MW];
  int n_chk = 0, n_fail = 0, n_fill = 0, n_cast = 0, w_beats = 0;
  bit k_prev = 0, k_last = 0;

  always #2 clk = ~clk;

  mei_cache_ctrl #(.ADDR_W(AW), .LINE_BYTES(LB), .SETS(NS)) uut (.*);

  function automatic int A(int s, int t, int w);
    return t * 64 + s * 16 + w * 4;
  endfunction

  task automatic check(bit ok, string r, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic cpu(bit wr, int a, logic [31:0] d, logic [3:0] be, output logic [31:0] rd);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = AW'(a); req_wdata = d; req_be = be;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    while (!resp_valid) @(negedge clk);
    rd = resp_rdata;
    if (wr) for (int b = 0; b < 4; b++) if (be[b]) golden[a >> 2][8*b +: 8] = d[8*b +: 8];
  endtask

  task automatic rdchk(int a, string r);
    logic [31:0] v;
    cpu(0, a, 0, 4'h0, v);
    check(v == golden[a >> 2], r, v, golden[a >> 2]);
  endtask

  task automatic wr(int a, logic [31:0] d, logic [3:0] be);
    logic [31:0] v;
    cpu(1, a, d, be, v);
  endtask

  task automatic snoop(int a, bit kill);
    @(negedge clk);
    snoop_valid = 1; snoop_kill = kill; snoop_addr = AW'(a);
    while (!snoop_ready) @(negedge clk);
    @(negedge clk);
    snoop_valid = 0;
    while (!snoop_ready) @(negedge clk);
  endtask

  // bus responder: one burst at a time, castout request handshake stretched
  initial begin
    int a; bit w;
    forever begin
      @(negedge clk);
      if (bus_req_valid) begin
        a = int'(bus_req_addr) >> 2; w = bus_req_write;
        if (w) @(negedge clk);
        bus_req_ready = 1;
        k_prev = k_last; k_last = w;
        if (w) n_cast++; else n_fill++;
        @(negedge clk);
        bus_req_ready = 0;
        for (int b = 0; b < BEATS; b++) begin
          if (b > 0) @(negedge clk);
          if (w) begin
            bus_wready = 1; mem[a + b] = bus_wdata; w_beats++;
          end else begin
            bus_rvalid = 1; bus_rdata = mem[a + b];
          end
        end
        @(negedge clk);
        bus_wready = 0; bus_rvalid = 0;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
    summary();
    $finish;
  end

  initial begin
    int f0, c0;
    logic [31:0] v;
    for (int i = 0; i < MW; i++) begin
      mem[i] = i * 32'h00010203 + 32'h5A000011;
      golden[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(req_ready && !resp_valid && !bus_req_valid && !bus_wvalid, "R1 idle after reset",
          {req_ready, resp_valid, bus_req_valid, bus_wvalid}, 32'h8);

    // R1 R3 read miss fills, second read hits
    f0 = n_fill;
    rdchk(A(0, 0, 1), "R3 miss data");
    check(n_fill == f0 + 1, "R1 first access fills", n_fill, f0 + 1);
    rdchk(A(0, 0, 2), "R3 hit data");
    check(n_fill == f0 + 1, "R3 hit no bus", n_fill, f0 + 1);

    // R4 partial write hit
    f0 = n_fill; c0 = n_cast;
    wr(A(0, 0, 1), 32'hDEADBEEF, 4'b0101);
    rdchk(A(0, 0, 1), "R4 byte merge");
    check(n_fill == f0 && n_cast == c0, "R4 no bus traffic", n_fill + n_cast, f0 + c0);

    // R6 R7 eviction order
    rdchk(A(0, 1, 0), "R6 second way fill");
    f0 = n_fill; c0 = n_cast;
    rdchk(A(0, 2, 3), "R7 fill after castout");
    check(n_cast == c0 + 1, "R7 dirty victim castout", n_cast, c0 + 1);
    check(k_prev == 1 && k_last == 0, "R7 castout before fill", {k_prev, k_last}, 32'h2);
    for (int w = 0; w < BEATS; w++)
      check(mem[(A(0, 0, 0) >> 2) + w] == golden[(A(0, 0, 0) >> 2) + w], "R2 R7 castout beat",
            mem[(A(0, 0, 0) >> 2) + w], golden[(A(0, 0, 0) >> 2) + w]);
    f0 = n_fill;
    rdchk(A(0, 1, 2), "R6 recent way kept");
    check(n_fill == f0, "R6 LRU kept tag1", n_fill, f0);
    c0 = n_cast;
    rdchk(A(0, 0, 1), "R6 clean victim refill");
    check(n_fill == f0 + 1 && n_cast == c0, "R7 clean victim no castout", n_cast, c0);

    // R5 R8 write miss then snooped read of Modified
    f0 = n_fill; c0 = n_cast;
    wr(A(1, 0, 2), 32'h12345678, 4'hF);
    check(n_fill == f0 + 1, "R5 write miss fills", n_fill, f0 + 1);
    rdchk(A(1, 0, 2), "R5 merged data");
    snoop(A(1, 0, 0), 0);
    check(n_cast == c0 + 1, "R8 snoop read castout", n_cast, c0 + 1);
    check(mem[A(1, 0, 2) >> 2] == 32'h12345678, "R8 castout data", mem[A(1, 0, 2) >> 2], 32'h12345678);
    rdchk(A(1, 0, 2), "R8 reread");
    check(n_fill == f0 + 2, "R8 line invalid after snoop", n_fill, f0 + 2);

    // R8 snooped read of Exclusive
    rdchk(A(1, 3, 0), "R8 exclusive fill");
    f0 = n_fill; c0 = n_cast;
    snoop(A(1, 3, 0), 0);
    check(n_cast == c0, "R8 exclusive no castout", n_cast, c0);
    rdchk(A(1, 3, 0), "R8 exclusive reread");
    check(n_fill == f0 + 1, "R8 exclusive invalidated", n_fill, f0 + 1);

    // R9 kill discards Modified data
    wr(A(2, 1, 1), 32'hCAFEF00D, 4'hF);
    f0 = n_fill; c0 = n_cast;
    snoop(A(2, 1, 0), 1);
    check(n_cast == c0, "R9 kill no castout", n_cast, c0);
    for (int w = 0; w < BEATS; w++) golden[(A(2, 1, 0) >> 2) + w] = mem[(A(2, 1, 0) >> 2) + w];
    rdchk(A(2, 1, 1), "R9 data from memory");
    check(n_fill == f0 + 1, "R9 line invalidated", n_fill, f0 + 1);

    // R8 snoop miss
    f0 = n_fill; c0 = n_cast;
    snoop(A(3, 5, 0), 0);
    check(n_fill == f0 && n_cast == c0, "R8 snoop miss quiet", n_fill + n_cast, f0 + c0);

    // R10 snoop ahead of processor request
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = AW'(A(3, 0, 0));
    snoop_valid = 1; snoop_kill = 1; snoop_addr = AW'(A(3, 7, 0));
    #1;
    check(!req_ready && snoop_ready, "R10 snoop first", {req_ready, snoop_ready}, 32'h1);
    @(negedge clk);
    snoop_valid = 0;
    #1;
    check(!req_ready && !snoop_ready, "R10 busy blocks", {req_ready, snoop_ready}, 32'h0);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    while (!resp_valid) @(negedge clk);
    check(resp_rdata == golden[A(3, 0, 0) >> 2], "R10 request served", resp_rdata, golden[A(3, 0, 0) >> 2]);

    // R2 R4 R6 sweep over all sets, four tags, all words
    for (int s = 0; s < NS; s++)
      for (int t = 0; t < 4; t++)
        for (int w = 0; w < BEATS; w++)
          wr(A(s, t, w), 32'hC0000000 + s * 32'h10101 + t * 32'h01000100 + w * 32'h11,
             4'((s * 5 + t * 3 + w) % 15 + 1));
    for (int s = 0; s < NS; s++)
      for (int t = 0; t < 4; t++)
        for (int w = 0; w < BEATS; w++) rdchk(A(s, t, w), "R4 R6 sweep readback");
    for (int s = 0; s < NS; s++) begin
      rdchk(A(s, 8, 0), "R6 flush read");
      rdchk(A(s, 9, 0), "R6 flush read");
    end
    for (int i = 0; i < 128; i++)
      check(mem[i] == golden[i], "R7 memory after flush", mem[i], golden[i]);
    check(w_beats == n_cast * BEATS, "R2 R11 castout beat count", w_beats, n_cast * BEATS);

    summary();
    $finish;
  end
endmodule